// File: doc/BRIEF.md
# Batched Register Access Command Engine

This engine sits behind a host-to-controller mailbox and serves power-register access commands. A command arrives on a valid/ready handshake. It carries a message type, a command id, a byte size and a snapshot of the mailbox write buffer. The engine checks the command and unpacks a list of 16-bit register addresses, and data bytes where the command has them, from that buffer. It then runs the accesses one after another on an external 8-bit register port.

Three operations are supported: a batch of writes, a batch of reads, and a masked read-modify-write on a single register. Read results go out through a byte-wide read-buffer write port, one byte per item. Every command, accepted or rejected, ends with a one-cycle completion strobe that carries an error flag and an error code.

Back-pressure rules: `cmd_ready` is high only while the engine is idle. A command is taken on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. The command fields and the buffer are sampled at that edge only. While the engine is busy, anything on the command inputs is ignored, and `cmd_valid` may stay high.

Top module: `rab_engine`

## Requirements
- R1: Only message type 0xFF is served. Any other type completes with `done_err`=1 and `done_code`=0x01, and makes no register access. This check has priority over R2 and R7.
- R2: The 4-bit command id selects write (0), read (1) or read-modify-write (2). Any other id completes with `done_code`=0x02 and makes no register access. This check has priority over R7.
- R3: Buffer byte n is `cmd_wbuf[8n+7:8n]`. The address of item k is {byte 2k+1, byte 2k}, so the low byte comes first.
- R4: A read of N items has byte size 2N. The value read for item k is sent to read-buffer index k. Each item produces exactly one read-buffer write, and these come in item order.
- R5: A write of N items has byte size 3N. The data byte of item k is buffer byte 2N+k. The writes reach the register port in item order.
- R6: Read-modify-write has byte size 4. The address is in bytes 0 and 1, the value in byte 2 and the mask in byte 3. The register is read once and then written once with (old AND NOT mask) OR (value AND mask).
- R7: Byte sizes that do not fit the id's formula, or that give an item count outside 1 to 5 (size 0 included), complete with `done_code`=0x03 and make no register access.
- R8: Accesses run one at a time in list order. If an address appears twice in one write batch, the later write is the one that remains.
- R9: `done` is a one-cycle pulse. It comes after the last register access and after the last read-buffer write, never in the same cycle as either. When `done` is high, `done_err`=0 and `done_code`=0x00 mean success.
- R10: After a command is accepted, `cmd_ready` stays low until the cycle after `done`. Command inputs that change during that time have no effect.
- R11: With `reg_en`=1 and `reg_we`=0 the port reads `reg_addr`, and `reg_rdata` is taken in the following cycle. With `reg_we`=1 the port writes `reg_wdata` at that edge. A read takes two cycles and a write takes one.
- R12: After reset, `cmd_ready`=1 and `done`, `reg_en` and `rbuf_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; command taken when both are high |
| cmd_msg | input | 8 | Message type |
| cmd_id | input | 4 | Operation selector |
| cmd_size | input | 8 | Payload byte count |
| cmd_wbuf | input | BUF_BYTES*8 | Write-buffer snapshot, byte n at bits 8n+7:8n |
| reg_en | output | 1 | Register port access strobe |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after a read strobe |
| rbuf_we | output | 1 | Read-buffer byte write strobe |
| rbuf_idx | output | IDX_W | Read-buffer byte index |
| rbuf_data | output | 8 | Read-buffer byte |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Error flag, valid with done |
| done_code | output | 8 | Error code, valid with done |

## Verification
The embedded properties are checked on every clock. They cover the single-cycle completion pulse and its separation from port activity, the rejection path (completion with the error flag on the next cycle and no access), the item-count bounds of accepted commands, that each read-buffer write follows a register read, the masked merge value of a read-modify-write, and the loss of `cmd_ready` after acceptance. Other behaviour can only be shown by the bench's scenarios against its own model of the register file: that buffer bytes end up at the right addresses and data positions, that a repeated address keeps the last write, that a masked update leaves exactly the unmasked bits, that the error codes follow the stated priority, and that garbage on the command inputs while busy is ignored.

// File: rtl/rab_pkg.sv
package rab_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_RMW   = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACC,
    S_WAIT,
    S_MODW,
    S_DONE
  } seq_state_e;

  localparam logic [7:0] MSG_PWR     = 8'hFF;
  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_BAD_MSG  = 8'h01;
  localparam logic [7:0] ST_BAD_CMD  = 8'h02;
  localparam logic [7:0] ST_BAD_SIZE = 8'h03;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  val;
    logic [7:0]  mask;
  } item_t;

endpackage

// File: rtl/rab_decode.sv
module rab_decode
  import rab_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int CNT_W     = 3
) (
  input  logic [7:0]       msg,
  input  logic [3:0]       cmd_id,
  input  logic [7:0]       size,
  output op_e              op,
  output logic [CNT_W-1:0] count,
  output logic             bad,
  output logic [7:0]       code
);

  always_comb begin
    logic hit;
    hit   = 1'b0;
    op    = OP_WRITE;
    count = '0;
    bad   = 1'b0;
    code  = ST_OK;
    if (msg != MSG_PWR) begin
      bad  = 1'b1;
      code = ST_BAD_MSG;
    end else begin
      case (cmd_id)
        4'd0: begin
          op = OP_WRITE;
          for (int k = 1; k <= MAX_ITEMS; k++) begin
            if (size == 8'(3 * k)) begin
              hit   = 1'b1;
              count = CNT_W'(k);
            end
          end
        end
        4'd1: begin
          op = OP_READ;
          for (int k = 1; k <= MAX_ITEMS; k++) begin
            if (size == 8'(2 * k)) begin
              hit   = 1'b1;
              count = CNT_W'(k);
            end
          end
        end
        4'd2: begin
          op = OP_RMW;
          if (size == 8'd4) begin
            hit   = 1'b1;
            count = CNT_W'(1);
          end
        end
        default: begin
          bad  = 1'b1;
          code = ST_BAD_CMD;
        end
      endcase
      if (!bad && !hit) begin
        bad   = 1'b1;
        code  = ST_BAD_SIZE;
        count = '0;
      end
    end
  end

endmodule

// File: rtl/rab_unpack.sv
module rab_unpack
  import rab_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int CNT_W     = 3,
  parameter int IDX_W     = 3
) (
  input  logic [BUF_BYTES*8-1:0] wbuf,
  input  op_e                    op,
  input  logic [CNT_W-1:0]       count,
  input  logic [IDX_W-1:0]       idx,
  output item_t                  item
);

  logic [7:0] bytes [BUF_BYTES];

  generate
    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_split
      assign bytes[g] = wbuf[8*g +: 8];
    end
  endgenerate

  int lo_pos;
  int val_pos;

  always_comb begin
    logic [7:0] lo_b, hi_b, v_b, m_b;
    lo_pos  = 2 * int'(idx);
    val_pos = (op == OP_RMW) ? 2 : (2 * int'(count) + int'(idx));
    lo_b = '0;
    hi_b = '0;
    v_b  = '0;
    m_b  = '0;
    for (int k = 0; k < BUF_BYTES; k++) begin
      if (k == lo_pos)     lo_b = bytes[k];
      if (k == lo_pos + 1) hi_b = bytes[k];
      if (k == val_pos)    v_b  = bytes[k];
      if (k == 3)          m_b  = bytes[k];
    end
    item.addr = {hi_b, lo_b};
    item.val  = v_b;
    item.mask = (op == OP_RMW) ? m_b : 8'hFF;
  end

endmodule

// File: rtl/rab_seq.sv
module rab_seq
  import rab_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int CNT_W     = 3,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  op_e              dec_op,
  input  logic [CNT_W-1:0] dec_count,
  input  logic             dec_bad,
  input  logic [7:0]       dec_code,
  output op_e              cur_op,
  output logic [CNT_W-1:0] cur_count,
  output logic [IDX_W-1:0] cur_idx,
  input  item_t            item,
  output logic             reg_en,
  output logic             reg_we,
  output logic [15:0]      reg_addr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  output logic             rbuf_we,
  output logic [IDX_W-1:0] rbuf_idx,
  output logic [7:0]       rbuf_data,
  output logic             done,
  output logic             done_err,
  output logic [7:0]       done_code
);

  seq_state_e       state_q;
  op_e              op_q;
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       mod_q;
  logic             err_q;
  logic [7:0]       code_q;
  logic             last;

  assign last = (int'(idx_q) == int'(count_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_WRITE;
      count_q <= '0;
      idx_q   <= '0;
      mod_q   <= '0;
      err_q   <= 1'b0;
      code_q  <= ST_OK;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          idx_q <= '0;
          if (dec_bad) begin
            err_q   <= 1'b1;
            code_q  <= dec_code;
            state_q <= S_DONE;
          end else begin
            err_q   <= 1'b0;
            code_q  <= ST_OK;
            op_q    <= dec_op;
            count_q <= dec_count;
            state_q <= S_ACC;
          end
        end
        S_ACC: begin
          if (op_q == OP_WRITE) begin
            if (last) state_q <= S_DONE;
            else      idx_q   <= idx_q + 1'b1;
          end else begin
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (op_q == OP_RMW) begin
            mod_q   <= (reg_rdata & ~item.mask) | (item.val & item.mask);
            state_q <= S_MODW;
          end else if (last) begin
            state_q <= S_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_ACC;
          end
        end
        S_MODW:  state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign cur_op    = op_q;
  assign cur_count = count_q;
  assign cur_idx   = idx_q;
  assign reg_en    = (state_q == S_ACC) || (state_q == S_MODW);
  assign reg_we    = ((state_q == S_ACC) && (op_q == OP_WRITE)) || (state_q == S_MODW);
  assign reg_addr  = item.addr;
  assign reg_wdata = (state_q == S_MODW) ? mod_q : item.val;
  assign rbuf_we   = (state_q == S_WAIT) && (op_q == OP_READ);
  assign rbuf_idx  = idx_q;
  assign rbuf_data = reg_rdata;
  assign done      = (state_q == S_DONE);
  assign done_err  = err_q;
  assign done_code = code_q;

  // R9: completion is a single pulse, isolated from port activity
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!reg_en && !rbuf_we));
  p_ok_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_code == ST_OK));
  // R7 (also R1, R2): a rejected command completes at once with no access
  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && dec_bad) |=> (done && done_err && !reg_en));
  p_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !dec_bad) |->
      (dec_count != '0 && int'(dec_count) <= MAX_ITEMS));
  // R10: busy after acceptance
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R4: every read-buffer byte follows a register read
  p_rbuf_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_we |-> $past(reg_en && !reg_we));
  // R6: masked merge written back
  p_rmw_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && cur_op == OP_RMW) |->
      (reg_wdata == (($past(reg_rdata) & ~item.mask) | (item.val & item.mask))));

endmodule

// File: rtl/rab_engine.sv
module rab_engine
  import rab_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int MAX_ITEMS = 5,
  localparam int CNT_W    = $clog2(MAX_ITEMS + 1),
  localparam int IDX_W    = (MAX_ITEMS > 1) ? $clog2(MAX_ITEMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [7:0]             cmd_msg,
  input  logic [3:0]             cmd_id,
  input  logic [7:0]             cmd_size,
  input  logic [BUF_BYTES*8-1:0] cmd_wbuf,
  output logic                   reg_en,
  output logic                   reg_we,
  output logic [15:0]            reg_addr,
  output logic [7:0]             reg_wdata,
  input  logic [7:0]             reg_rdata,
  output logic                   rbuf_we,
  output logic [IDX_W-1:0]       rbuf_idx,
  output logic [7:0]             rbuf_data,
  output logic                   done,
  output logic                   done_err,
  output logic [7:0]             done_code
);

  op_e                   dec_op, cur_op;
  logic [CNT_W-1:0]      dec_count, cur_count;
  logic                  dec_bad;
  logic [7:0]            dec_code;
  logic [IDX_W-1:0]      cur_idx;
  item_t                 item;
  logic [BUF_BYTES*8-1:0] wbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wbuf_q <= '0;
    else if (cmd_valid && cmd_ready)  wbuf_q <= cmd_wbuf;
  end

  rab_decode #(.MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W)) u_decode (
    .msg    (cmd_msg),
    .cmd_id (cmd_id),
    .size   (cmd_size),
    .op     (dec_op),
    .count  (dec_count),
    .bad    (dec_bad),
    .code   (dec_code)
  );

  rab_unpack #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_unpack (
    .wbuf  (wbuf_q),
    .op    (cur_op),
    .count (cur_count),
    .idx   (cur_idx),
    .item  (item)
  );

  rab_seq #(.MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .dec_op    (dec_op),
    .dec_count (dec_count),
    .dec_bad   (dec_bad),
    .dec_code  (dec_code),
    .cur_op    (cur_op),
    .cur_count (cur_count),
    .cur_idx   (cur_idx),
    .item      (item),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rbuf_we   (rbuf_we),
    .rbuf_idx  (rbuf_idx),
    .rbuf_data (rbuf_data),
    .done      (done),
    .done_err  (done_err),
    .done_code (done_code)
  );

endmodule

// File: tb/tb_rab_engine.sv
`timescale 1ns/1ps
module tb_rab_engine;
  localparam int BUF_BYTES = 16;
  localparam int MAX_ITEMS = 5;
  localparam int IDX_W     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_msg = '0;
  logic [3:0] cmd_id = '0;
  logic [7:0] cmd_size = '0;
  logic [BUF_BYTES*8-1:0] cmd_wbuf = '0;
  logic reg_en, reg_we;
  logic [15:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata = '0;
  logic rbuf_we;
  logic [IDX_W-1:0] rbuf_idx;
  logic [7:0] rbuf_data;
  logic done, done_err;
  logic [7:0] done_code;

  always #4 clk = ~clk;

  rab_engine #(.BUF_BYTES(BUF_BYTES), .MAX_ITEMS(MAX_ITEMS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_msg(cmd_msg), .cmd_id(cmd_id), .cmd_size(cmd_size), .cmd_wbuf(cmd_wbuf),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rbuf_we(rbuf_we), .rbuf_idx(rbuf_idx),
    .rbuf_data(rbuf_data), .done(done), .done_err(done_err), .done_code(done_code)
  );

  logic [7:0] bb [BUF_BYTES];
  logic [7:0] hw_mem [int];
  logic [7:0] ref_mem [int];
  int exp_wr[$], exp_rb[$], exp_st[$], exp_acc[$];
  int vectors = 0, fails = 0, acc_cnt = 0;
  bit started = 1'b0;
  string tag = "R12";

  function automatic logic [7:0] seed(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] hw_rd(int a);
    return hw_mem.exists(a) ? hw_mem[a] : seed(a);
  endfunction
  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed(a);
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // Register file model, R11 timing: read data the cycle after the strobe
  always @(posedge clk) begin
    if (reg_en) begin
      if (reg_we) hw_mem[int'(reg_addr)] = reg_wdata;
      else        reg_rdata <= hw_rd(int'(reg_addr));
    end
  end

  // Monitor: pops scoreboard items as the design produces them
  always @(negedge clk) begin
    if (rst_n && started) begin
      if (reg_en) acc_cnt++;
      if (reg_en && reg_we) begin
        if (exp_wr.size() == 0) chk(tag, "unexpected register write", int'({reg_addr, reg_wdata}), -1);
        else chk(tag, "register write addr/data", int'({reg_addr, reg_wdata}), exp_wr.pop_front());
      end
      if (rbuf_we) begin
        if (exp_rb.size() == 0) chk(tag, "unexpected read-buffer write", int'({rbuf_idx, rbuf_data}), -1);
        else chk(tag, "read-buffer idx/data", int'({rbuf_idx, rbuf_data}), exp_rb.pop_front());
      end
      if (done) begin
        if (exp_st.size() == 0) chk("R9", "unexpected done", 1, 0);
        else begin
          chk("R9", "completion status", int'({done_err, done_code}), exp_st.pop_front());
          chk("R11", "register access count", acc_cnt, exp_acc.pop_front());
          chk("R9", "items left at done", exp_wr.size() + exp_rb.size(), 0);
        end
        acc_cnt = 0;
      end
    end
  end

  task automatic clear_bb();
    for (int k = 0; k < BUF_BYTES; k++) bb[k] = 8'h00;
  endtask
  task automatic put_addr(int k, logic [15:0] a);
    bb[2*k]     = a[7:0];
    bb[2*k + 1] = a[15:8];
  endtask

  // Driver: computes expectations from the requirements, then issues the command
  task automatic run_cmd(logic [7:0] msg, logic [3:0] id, logic [7:0] size, string rq, bit hold);
    int code, n, s;
    code = 0; n = 0; s = int'(size);
    if (msg != 8'hFF) code = 1;
    else if (id > 4'd2) code = 2;
    else begin
      case (id)
        4'd0: if (s % 3 == 0) n = s / 3;
        4'd1: if (s % 2 == 0) n = s / 2;
        default: if (s == 4) n = 1;
      endcase
      if (n < 1 || n > MAX_ITEMS) code = 3;
    end
    if (code != 0) begin
      exp_st.push_back(256 | code);
      exp_acc.push_back(0);
    end else begin
      if (id == 4'd1) begin
        for (int k = 0; k < n; k++)
          exp_rb.push_back(k * 256 + int'(ref_rd(int'({bb[2*k+1], bb[2*k]}))));
        exp_acc.push_back(n);
      end else if (id == 4'd0) begin
        for (int k = 0; k < n; k++) begin
          int a;
          a = int'({bb[2*k+1], bb[2*k]});
          ref_mem[a] = bb[2*n + k];
          exp_wr.push_back(a * 256 + int'(bb[2*n + k]));
        end
        exp_acc.push_back(n);
      end else begin
        int a;
        logic [7:0] nw;
        a = int'({bb[1], bb[0]});
        nw = (ref_rd(a) & ~bb[3]) | (bb[2] & bb[3]);
        ref_mem[a] = nw;
        exp_wr.push_back(a * 256 + int'(nw));
        exp_acc.push_back(2);
      end
      exp_st.push_back(0);
    end
    @(negedge clk);
    tag = rq;
    cmd_msg = msg; cmd_id = id; cmd_size = size;
    for (int k = 0; k < BUF_BYTES; k++) cmd_wbuf[8*k +: 8] = bb[k];
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    chk("R10", "cmd_ready after accept", int'(cmd_ready), 0);
    if (hold) begin
      cmd_msg = 8'h00; cmd_id = 4'd9; cmd_size = 8'h77; cmd_wbuf = '1;
    end else cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    clear_bb();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "cmd_ready after reset", int'(cmd_ready), 1);
    chk("R12", "done after reset", int'(done), 0);
    chk("R12", "reg_en after reset", int'(reg_en), 0);
    chk("R12", "rbuf_we after reset", int'(rbuf_we), 0);
    started = 1'b1;

    // R5, R3: three writes, data after the address block
    clear_bb();
    put_addr(0, 16'h0010); put_addr(1, 16'h1234); put_addr(2, 16'hBEEF);
    bb[6] = 8'hA1; bb[7] = 8'hB2; bb[8] = 8'hC3;
    run_cmd(8'hFF, 4'd0, 8'd9, "R5", 1'b0);
    // R3, R4: read them back
    run_cmd(8'hFF, 4'd1, 8'd6, "R3", 1'b0);
    // R4 with R10: five reads, command inputs scrambled while busy
    clear_bb();
    put_addr(0, 16'h0010); put_addr(1, 16'h0011); put_addr(2, 16'h8001);
    put_addr(3, 16'h1234); put_addr(4, 16'h00FF);
    run_cmd(8'hFF, 4'd1, 8'd10, "R4", 1'b1);
    // R6: masked update, then read back
    clear_bb();
    put_addr(0, 16'h0010); bb[2] = 8'h0F; bb[3] = 8'h3C;
    run_cmd(8'hFF, 4'd2, 8'd4, "R6", 1'b0);
    bb[2] = 8'h00; bb[3] = 8'h00;
    run_cmd(8'hFF, 4'd1, 8'd2, "R6", 1'b0);
    clear_bb();
    put_addr(0, 16'h4444); bb[2] = 8'hF0; bb[3] = 8'hFF;
    run_cmd(8'hFF, 4'd2, 8'd4, "R6", 1'b0);
    // R8: repeated address in one batch keeps the later write
    clear_bb();
    put_addr(0, 16'h0020); put_addr(1, 16'h0020); put_addr(2, 16'h0021);
    bb[6] = 8'h11; bb[7] = 8'h22; bb[8] = 8'h33;
    run_cmd(8'hFF, 4'd0, 8'd9, "R8", 1'b0);
    clear_bb();
    put_addr(0, 16'h0020); put_addr(1, 16'h0021);
    run_cmd(8'hFF, 4'd1, 8'd4, "R8", 1'b0);
    // R1, R2, R7: rejected commands with no access
    clear_bb();
    put_addr(0, 16'h0020); put_addr(1, 16'h0021);
    bb[4] = 8'hEE; bb[5] = 8'hDD;
    run_cmd(8'hEF, 4'd1, 8'd2, "R1", 1'b0);
    run_cmd(8'h00, 4'd7, 8'd3, "R1", 1'b0);
    run_cmd(8'hFF, 4'd3, 8'd6, "R2", 1'b0);
    run_cmd(8'hFF, 4'd15, 8'd4, "R2", 1'b0);
    run_cmd(8'hFF, 4'd0, 8'd4, "R7", 1'b0);
    run_cmd(8'hFF, 4'd1, 8'd12, "R7", 1'b0);
    run_cmd(8'hFF, 4'd1, 8'd0, "R7", 1'b0);
    run_cmd(8'hFF, 4'd2, 8'd3, "R7", 1'b0);
    run_cmd(8'hFF, 4'd0, 8'd18, "R7", 1'b0);
    // R7: registers untouched by the rejected commands
    run_cmd(8'hFF, 4'd1, 8'd4, "R7", 1'b0);
    // R5: full batch of five writes, then read back
    clear_bb();
    for (int k = 0; k < 5; k++) begin
      put_addr(k, 16'(16'h0300 + 16'(k * 7)));
      bb[10 + k] = 8'(8'h90 + k);
    end
    run_cmd(8'hFF, 4'd0, 8'd15, "R5", 1'b0);
    run_cmd(8'hFF, 4'd1, 8'd10, "R4", 1'b0);

    repeat (3) @(negedge clk);
    chk("R9", "scoreboard drained", exp_wr.size() + exp_rb.size() + exp_st.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule